// File: doc/BRIEF.md
# Two-Wire Target with 16-bit Register Bank

This block is an I2C target. It connects the two bus wires to an internal bank of 16-bit registers. The block runs entirely on a system clock. It passes SCL and SDA through a synchronizer and recognises clock edges, START and STOP from the sampled levels. The block never drives SDA high. It only pulls SDA low, through `sda_pull_low`, and the board's pull-up supplies the high level.

Every transaction begins with the 7-bit target address. The first byte after a write address is a command byte, which sets a register pointer. That pointer survives a repeated START. A write carries two data bytes, high byte first, and the register takes both bytes in one update once the low byte has arrived. A read issued after a repeated START returns the pointed-at register as two bytes, high byte first. Chaining a read and a write-back gives a read-modify-write. Writing the clear key to the clear command wipes the whole bank, and the target answers that final byte with a NACK.

The controller has twelve states:
- IDLE: waiting for a START.
- ADDR: shifting in the address byte.
- ADDR_ACK: the ninth clock after the address.
- CMD and CMD_ACK: the command byte and its acknowledge.
- WMSB and WMSB_ACK: the high data byte and its acknowledge.
- WLSB and WLSB_ACK: the low data byte and its acknowledge.
- RDBYTE: shifting out a byte.
- RDACK: sampling the controller's acknowledge.
- IGNORE: deaf until the next START or STOP.

A STOP moves any state to IDLE. A START moves any state to ADDR. Transitions driven by bytes happen on the SCL fall that ends the eighth bit or the ninth bit:
- ADDR goes to ADDR_ACK on a match, or to IGNORE on a miss.
- ADDR_ACK goes to RDBYTE on a read, or to CMD on a write.
- The write path runs CMD, CMD_ACK, WMSB, WMSB_ACK, WLSB, WLSB_ACK and then IGNORE.
- RDBYTE goes to RDACK after eight bits.
- RDACK goes back to RDBYTE for the low byte when the controller acknowledged the high byte. Otherwise it goes to IGNORE.

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges an address byte whose seven address bits, sent MSB first, equal binary 0100 followed by `addr_pins[2]`, `addr_pins[1]`, `addr_pins[0]`. The eighth bit selects the direction: 0 is write, 1 is read. To acknowledge, SDA is held low for the whole ninth clock high time.
- R2: On an address mismatch, SDA stays released on the ninth clock and on every later bit until the next START. No register changes.
- R3: A write consists of the address with W, a command byte, a high data byte and a low data byte, each acknowledged. The register selected by the command takes the 16-bit value as one update after the low byte. A transfer that ends before the low byte leaves the register unchanged.
- R4: A repeated START followed by the address with R returns the register selected by the last command byte. The high byte comes first, and each byte is sent MSB first.
- R5: A NACK from the controller after a read byte ends the transfer. SDA stays released until the next START.
- R6: Read-modify-write works. After command, repeated START, two-byte read, repeated START, address with W, command and two data bytes, the written value reads back.
- R7: Writing key 0x5A5A to command 0x3F clears every register to 0x0000, and the target NACKs that low data byte. Any other value written to command 0x3F is acknowledged and changes nothing.
- R8: A START or STOP at any point restarts framing. A STOP releases SDA, and a START expects a fresh address byte.
- R9: `sda_pull_low` changes only while SCL is low.
- R10: After reset, SDA is released and all registers read 0x0000.
- R11: With the default 8 registers, commands 0x00 to 0x07 select registers. Other commands, except 0x3F, are acknowledged, ignore writes and read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| addr_pins | input | 3 | Low three address bits from board straps |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A miscounted bit position shows up within one byte as an acknowledge bit, or a read data bit, in the wrong clock slot. A stale or corrupted command pointer shows up only at the next readback, as data from the wrong register. A write that is committed early or split shows up when a transfer is cut short after the high byte, and the register is then read. A drive that stays stuck low after a NACK or STOP shows up on the very next clock high phase, as a bus that never returns high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WMSB,
        ST_WMSB_ACK,
        ST_WLSB,
        ST_WLSB_ACK,
        ST_RDBYTE,
        ST_RDACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sr, sda_sr;
    logic         scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[TOP-1:0], scl_i};
            sda_sr <= {sda_sr[TOP-1:0], sda_i};
            scl_d  <= scl_sr[TOP];
            sda_d  <= sda_sr[TOP];
        end
    end

    assign scl_lvl  = scl_sr[TOP];
    assign sda_lvl  = sda_sr[TOP];
    assign scl_rise = scl_lvl & ~scl_d;
    assign scl_fall = ~scl_lvl & scl_d;
    assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NREG  = 8,
    parameter int IDX_W = 8,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             clr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    logic [NREG-1:0][DW-1:0] bank_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (clr)
                q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= wr_data;
        end

        assign bank_vec[g] = q;

        // R3
        word_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !clr && wr_idx == IDX_W'(g)) |=> (q == $past(wr_data)));

        // R7
        clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (q == '0));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = bank_vec[i];
    end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int          NREG        = 8,
    parameter logic [3:0]  ADDR_HI     = 4'b0100,
    parameter logic [7:0]  CLR_CMD     = 8'h3F,
    parameter logic [15:0] CLR_KEY     = 16'h5A5A,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] addr_pins,
    output logic       sda_pull_low
);
    localparam int BYTEW  = 8;
    localparam int DATA_W = 2 * BYTEW;
    localparam int CNTW   = $clog2(BYTEW + 1);
    localparam logic [CNTW-1:0] LAST_RX = CNTW'(BYTEW);
    localparam logic [CNTW-1:0] LAST_TX = CNTW'(BYTEW - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tgt_state_e        state_q, state_d;
    logic [CNTW-1:0]   bit_cnt_q;
    logic [BYTEW-1:0]  shreg_q, ptr_q, msb_q;
    logic [DATA_W-1:0] rd_word_q, rd_data, wr_word;
    logic              rw_q, lsb_phase_q, mack_q, sda_low_q;
    logic              byte_done, addr_hit, clr_hit, bank_wr, bank_clr;

    assign byte_done = scl_fall && (bit_cnt_q == LAST_RX);
    assign addr_hit  = (shreg_q[BYTEW-1:1] == {ADDR_HI, addr_pins});
    assign wr_word   = {msb_q, shreg_q};
    assign clr_hit   = (ptr_q == CLR_CMD) && (wr_word == CLR_KEY);
    assign bank_wr   = (state_q == ST_WLSB) && byte_done && !clr_hit && !stop_ev && !start_ev;
    assign bank_clr  = (state_q == ST_WLSB) && byte_done && clr_hit && !stop_ev && !start_ev;

    i2c_reg_bank #(.NREG(NREG), .IDX_W(BYTEW), .DW(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr),
        .clr     (bank_clr),
        .wr_idx  (ptr_q),
        .wr_data (wr_word),
        .rd_idx  (ptr_q),
        .rd_data (rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev)
            state_d = ST_IDLE;
        else if (start_ev)
            state_d = ST_ADDR;
        else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = rw_q ? ST_RDBYTE : ST_CMD;
                ST_CMD:      if (byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall)  state_d = ST_WMSB;
                ST_WMSB:     if (byte_done) state_d = ST_WMSB_ACK;
                ST_WMSB_ACK: if (scl_fall)  state_d = ST_WLSB;
                ST_WLSB:     if (byte_done) state_d = ST_WLSB_ACK;
                ST_WLSB_ACK: if (scl_fall)  state_d = ST_IGNORE;
                ST_RDBYTE:   if (scl_fall && bit_cnt_q == LAST_TX) state_d = ST_RDACK;
                ST_RDACK:    if (scl_fall)  state_d = (mack_q && !lsb_phase_q) ? ST_RDBYTE : ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            ptr_q       <= '0;
            msb_q       <= '0;
            rd_word_q   <= '0;
            rw_q        <= 1'b0;
            lsb_phase_q <= 1'b0;
            mack_q      <= 1'b0;
            sda_low_q   <= 1'b0;
        end else if (stop_ev || start_ev) begin
            bit_cnt_q   <= '0;
            lsb_phase_q <= 1'b0;
            sda_low_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_CMD, ST_WMSB, ST_WLSB: begin
                    if (scl_rise) begin
                        shreg_q   <= {shreg_q[BYTEW-2:0], sda_lvl};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt_q <= '0;
                        case (state_q)
                            ST_ADDR: begin
                                rw_q      <= shreg_q[0];
                                sda_low_q <= addr_hit;
                            end
                            ST_CMD: begin
                                ptr_q     <= shreg_q;
                                sda_low_q <= 1'b1;
                            end
                            ST_WMSB: begin
                                msb_q     <= shreg_q;
                                sda_low_q <= 1'b1;
                            end
                            default: sda_low_q <= !clr_hit;
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            rd_word_q <= rd_data;
                            shreg_q   <= rd_data[DATA_W-1 -: BYTEW];
                            sda_low_q <= ~rd_data[DATA_W-1];
                            bit_cnt_q <= '0;
                        end else begin
                            sda_low_q <= 1'b0;
                        end
                    end
                end
                ST_CMD_ACK, ST_WMSB_ACK, ST_WLSB_ACK: begin
                    if (scl_fall) sda_low_q <= 1'b0;
                end
                ST_RDBYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt_q == LAST_TX) begin
                            sda_low_q <= 1'b0;
                            bit_cnt_q <= '0;
                        end else begin
                            sda_low_q <= ~shreg_q[BYTEW-2];
                            shreg_q   <= {shreg_q[BYTEW-2:0], 1'b0};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) mack_q <= ~sda_lvl;
                    if (scl_fall && mack_q && !lsb_phase_q) begin
                        lsb_phase_q <= 1'b1;
                        shreg_q     <= rd_word_q[BYTEW-1:0];
                        sda_low_q   <= ~rd_word_q[BYTEW-1];
                        bit_cnt_q   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_low = sda_low_q;

    // R1
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= LAST_RX);

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_pull_low);

    // R7
    clear_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_clr |=> !sda_pull_low);

    // R8
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state_q == ST_ADDR && bit_cnt_q == '0));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state_q == ST_IDLE && !sda_pull_low));

    // R9
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev))
            |-> $stable(sda_pull_low));

endmodule

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
    localparam int          Q       = 8;
    localparam int          NREG    = 8;
    localparam logic [7:0]  CLR_CMD = 8'h3F;
    localparam logic [15:0] CLR_KEY = 16'h5A5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       sda_pull_low;
    wire        sda_bus = sda_m & ~sda_pull_low;

    int total = 0;
    int bad = 0;
    int r9_viol = 0;
    logic [15:0] model [NREG];

    always #10 clk = ~clk;

    i2c_reg_target uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .addr_pins    (pins),
        .sda_pull_low (sda_pull_low)
    );

    // R9 monitor: drive must not move while SCL stays high
    logic scl_prev = 1'b1;
    logic drv_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_pull_low != drv_prev))
            r9_viol++;
        scl_prev = scl_m;
        drv_prev = sda_pull_low;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [7:0] c);
        return (c < NREG) ? model[c[2:0]] : 16'h0000;
    endfunction

    function automatic logic [3:0] exp_wr_acks(input logic [7:0] c, input logic [15:0] d);
        return (c == CLR_CMD && d == CLR_KEY) ? 4'b1110 : 4'b1111;
    endfunction

    function automatic void model_wr(input logic [7:0] c, input logic [15:0] d);
        if (c == CLR_CMD && d == CLR_KEY) begin
            for (int i = 0; i < NREG; i++) model[i] = 16'h0000;
        end else if (c < NREG) begin
            model[c[2:0]] = d;
        end
    endfunction

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; hold();
            scl_m = 1'b1; hold();
        end
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold();
            scl_m = 1'b1; hold(); hold();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        acked = ~sda_bus;
        hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl_m = 1'b1; hold();
            b[i] = sda_bus;
            hold();
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; hold();
        scl_m = 1'b1; hold(); hold();
        scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] c, input logic [15:0] d, output logic [3:0] acks);
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, acks[3]);
        send_byte(c, acks[2]);
        send_byte(d[15:8], acks[1]);
        send_byte(d[7:0], acks[0]);
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] c, output logic [15:0] d, output logic [2:0] acks);
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, acks[2]);
        send_byte(c, acks[1]);
        bus_start();
        send_byte({4'b0100, pins, 1'b1}, acks[0]);
        recv_byte(d[15:8], 1'b1);
        recv_byte(d[7:0], 1'b0);
        bus_stop();
    endtask

    task automatic rmw_txn(input logic [7:0] c, input logic [15:0] mask,
                           output logic [15:0] old_v, output logic [6:0] acks);
        logic [15:0] nv;
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, acks[6]);
        send_byte(c, acks[5]);
        bus_start();
        send_byte({4'b0100, pins, 1'b1}, acks[4]);
        recv_byte(old_v[15:8], 1'b1);
        recv_byte(old_v[7:0], 1'b0);
        nv = old_v ^ mask;
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, acks[3]);
        send_byte(c, acks[2]);
        send_byte(nv[15:8], acks[1]);
        send_byte(nv[7:0], acks[0]);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [3:0]  wa;
        logic [2:0]  ra;
        logic [6:0]  ma;
        logic [15:0] rv, old_v;
        logic        a1, a2;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) model[i] = 16'h0000;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hold();

        // R10 reset state
        chk("R10 drive released", {31'd0, sda_pull_low}, 32'd0);
        for (int i = 0; i < NREG; i++) begin
            rd_txn(8'(i), rv, ra);
            chk("R10 reg zero", {16'd0, rv}, 32'd0);
        end

        // R1 / R3 / R4 directed write and readback
        wr_txn(8'h02, 16'hBEEF, wa);
        model_wr(8'h02, 16'hBEEF);
        chk("R1 R3 write acks", {28'd0, wa}, 32'hF);
        rd_txn(8'h02, rv, ra);
        chk("R4 read acks", {29'd0, ra}, 32'h7);
        chk("R4 readback", {16'd0, rv}, {16'd0, exp_rd(8'h02)});

        // R1 other pin strap
        pins = 3'b010;
        wr_txn(8'h05, 16'h1234, wa);
        model_wr(8'h05, 16'h1234);
        chk("R1 new strap acks", {28'd0, wa}, 32'hF);
        rd_txn(8'h05, rv, ra);
        chk("R1 new strap read", {16'd0, rv}, 32'h1234);

        // R2 mismatch: wrong low bits, then wrong high nibble
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b0}, a1);
        send_byte(8'h05, a2);
        chk("R2 address nack", {31'd0, a1}, 32'd0);
        chk("R2 ignored byte nack", {31'd0, a2}, 32'd0);
        send_byte(8'hFF, a2);
        send_byte(8'hFF, a2);
        bus_stop();
        bus_start();
        send_byte({4'b0101, pins, 1'b0}, a1);
        bus_stop();
        chk("R2 high nibble nack", {31'd0, a1}, 32'd0);
        rd_txn(8'h05, rv, ra);
        chk("R2 reg unchanged", {16'd0, rv}, 32'h1234);

        // R3 / R8 STOP after high byte: no commit
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, a1);
        send_byte(8'h05, a1);
        send_byte(8'hAA, a1);
        bus_stop();
        chk("R8 stop releases", {31'd0, sda_pull_low}, 32'd0);
        rd_txn(8'h05, rv, ra);
        chk("R3 partial no commit", {16'd0, rv}, 32'h1234);

        // R8 repeated START after command restarts framing
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, a1);
        send_byte(8'h02, a1);
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, a1);
        send_byte(8'h03, a1);
        send_byte(8'h0F, a1);
        send_byte(8'hF0, a2);
        bus_stop();
        model_wr(8'h03, 16'h0FF0);
        chk("R8 restart ack", {31'd0, a2}, 32'd1);
        rd_txn(8'h03, rv, ra);
        chk("R8 restart target", {16'd0, rv}, 32'h0FF0);
        rd_txn(8'h02, rv, ra);
        chk("R8 old pointer untouched", {16'd0, rv}, {16'd0, exp_rd(8'h02)});

        // R5 controller NACK after high byte
        bus_start();
        send_byte({4'b0100, pins, 1'b0}, a1);
        send_byte(8'h02, a1);
        bus_start();
        send_byte({4'b0100, pins, 1'b1}, a1);
        recv_byte(rv[15:8], 1'b0);
        hold();
        chk("R5 released after nack", {31'd0, sda_pull_low}, 32'd0);
        chk("R5 high byte", {24'd0, rv[15:8]}, {24'd0, exp_rd(8'h02) >> 8});
        recv_byte(rv[7:0], 1'b0);
        chk("R5 no further data", {24'd0, rv[7:0]}, 32'hFF);
        bus_stop();

        // R6 read-modify-write
        rmw_txn(8'h03, 16'h00FF, old_v, ma);
        chk("R6 rmw acks", {25'd0, ma}, 32'h7F);
        chk("R6 rmw old", {16'd0, old_v}, 32'h0FF0);
        model_wr(8'h03, 16'h0FF0 ^ 16'h00FF);
        rd_txn(8'h03, rv, ra);
        chk("R6 rmw result", {16'd0, rv}, {16'd0, exp_rd(8'h03)});

        // R11 out-of-range command
        wr_txn(8'h09, 16'h7777, wa);
        chk("R11 out-of-range acks", {28'd0, wa}, 32'hF);
        rd_txn(8'h09, rv, ra);
        chk("R11 out-of-range read", {16'd0, rv}, 32'd0);

        // R7 clear command with a non-key value
        wr_txn(CLR_CMD, 16'h1111, wa);
        chk("R7 non-key acks", {28'd0, wa}, {28'd0, exp_wr_acks(CLR_CMD, 16'h1111)});
        rd_txn(8'h05, rv, ra);
        chk("R7 non-key no effect", {16'd0, rv}, {16'd0, exp_rd(8'h05)});

        // random mix, seeded
        for (int n = 0; n < 24; n++) begin
            logic [7:0]  c;
            logic [15:0] d;
            int unsigned op;
            op = $urandom % 3;
            c  = 8'($urandom % 10);
            d  = 16'($urandom);
            if (op == 0) begin
                wr_txn(c, d, wa);
                chk("R3 random write acks", {28'd0, wa}, {28'd0, exp_wr_acks(c, d)});
                model_wr(c, d);
            end else if (op == 1) begin
                rd_txn(c, rv, ra);
                chk("R4 random read", {16'd0, rv}, {16'd0, exp_rd(c)});
            end else begin
                rmw_txn(c, d, old_v, ma);
                chk("R6 random rmw old", {16'd0, old_v}, {16'd0, exp_rd(c)});
                model_wr(c, old_v ^ d);
            end
        end

        // R7 full clear with key: last byte NACKed, bank zeroed
        wr_txn(8'h01, 16'hCAFE, wa);
        model_wr(8'h01, 16'hCAFE);
        wr_txn(CLR_CMD, CLR_KEY, wa);
        chk("R7 key nack", {28'd0, wa}, {28'd0, exp_wr_acks(CLR_CMD, CLR_KEY)});
        model_wr(CLR_CMD, CLR_KEY);
        for (int i = 0; i < NREG; i++) begin
            rd_txn(8'(i), rv, ra);
            chk("R7 cleared", {16'd0, rv}, {16'd0, exp_rd(8'(i))});
        end

        chk("R9 drive only moves with SCL low", r9_viol, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule